// File: doc/BRIEF.md
# Byte-Port Memory Word Access Bank

This block sits on the 8-bit I/O bus of a small microcontroller and lets its software reach 16-bit words in a memory addressed by 24-bit word addresses. Software loads the word address one byte at a time. For a store it also loads the two data bytes. It then writes a command byte and polls a status byte until the operation has started (stores) or its data has arrived (loads).

The block holds the address and data bytes and the three status flags. It presents a single request, with a write-enable, toward the memory arbiter. It learns from the controller when a request has been accepted and when load data comes back. Returned load data replaces both data bytes, so software reads the result through the same ports it uses to stage a store.

Only the low four bits of the port number are decoded. The block answers only when bit 3 of the port number is 0, which leaves the other half of the port space to a neighbouring peripheral.

Top module: `mio_regbank`

## Requirements
- R1: After reset the address and data registers are zero, all status flags are clear and `mem_req` is low.
- R2: A bus write with port bits [3:0] equal to 0, 1 or 2 loads address bits [7:0], [15:8] or [23:16] respectively. `mem_addr` shows the new value from the next cycle. Port bits [7:4] are not decoded.
- R3: Port codes 4 and 5 hold data bits [7:0] and [15:8]. They can be written, they read back on `in_port`, and `mem_wdata` shows them.
- R4: When port bit 3 is 1 a write changes nothing, and `in_port` reads zero. `in_port` also reads zero for the address ports 0, 1, 2 and for the unused port code 6.
- R5: Writing port 7 with bit 1 set starts a store and sets the write-pending flag (status bit 2). While that flag is set, `mem_req` and `mem_we` are high. The flag and the request drop in the cycle after `mem_op_begun`.
- R6: Writing port 7 with bit 0 set starts a load and sets the read-pending flag (status bit 1). A load request is `mem_req` high with `mem_we` low. It drops after `mem_op_begun`, but the read-pending flag stays set until the data returns.
- R7: When `mem_rd_valid` arrives for a launched load, both data bytes take `mem_rdata`, read-pending clears and read-done (status bit 0) sets, all in one edge. If the bus writes a data port in that same cycle, the returned data wins. `mem_rd_valid` is ignored when no load has been launched.
- R8: Writing any address port clears read-done. If load data returns in that same cycle, read-done ends up set.
- R9: A command bit for an operation kind that is already pending is ignored. Status bits [7:3] always read zero.
- R10: When a store and a load are both pending, the store is presented first. The first `mem_op_begun` retires only the store, and the load request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_id | input | 8 | Bus port number |
| out_port | input | 8 | Bus write data |
| wr_strobe | input | 1 | Bus write strobe |
| in_port | output | 8 | Bus read data, combinational from `port_id` |
| mem_req | output | 1 | Request toward the arbiter |
| mem_we | output | 1 | Request is a store |
| mem_addr | output | 24 | Word address |
| mem_wdata | output | 16 | Store data |
| mem_op_begun | input | 1 | Controller accepted the presented request |
| mem_rd_valid | input | 1 | Load data valid |
| mem_rdata | input | 16 | Load data |

## Verification
Two pairs of functions can land on the same edge. The first is a load return together with a bus write to a data port, since both load the data bytes. The second is a load return together with an address-byte write, since one sets read-done and the other clears it. The bench drives each pair in one cycle, with the bus strobe and `mem_rd_valid` raised together. It then judges the result at the ports: the data bytes must equal the returned word, read-done must be set, and the new address byte must still have been taken.

// File: rtl/mio_pkg.sv
package mio_pkg;
  // port codes within the low three bits of the port number
  localparam int PORT_DATA_BASE = 4;
  localparam int PORT_CMD       = 7;
  // command byte bits
  localparam int CMD_WR_BIT = 1;
  localparam int CMD_RD_BIT = 0;
  // status byte bits
  localparam int ST_WRX_BIT = 2;
  localparam int ST_RDX_BIT = 1;
  localparam int ST_RDD_BIT = 0;

  function automatic logic [7:0] status_pack(input logic wrx, input logic rdx,
                                             input logic rdd);
    logic [7:0] s;
    s = '0;
    s[ST_WRX_BIT] = wrx;
    s[ST_RDX_BIT] = rdx;
    s[ST_RDD_BIT] = rdd;
    return s;
  endfunction

  function automatic logic port_is_local(input logic [7:0] pid);
    return ~pid[3];
  endfunction
endpackage

// File: rtl/mio_port_decode.sv
module mio_port_decode
  import mio_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int DATA_BYTES = 2
) (
  input  logic [7:0]            port_id,
  input  logic                  wr_strobe,
  output logic [ADDR_BYTES-1:0] addr_we,
  output logic [DATA_BYTES-1:0] data_we,
  output logic [DATA_BYTES-1:0] data_rsel,
  output logic                  cmd_we,
  output logic                  stat_rsel
);
  logic       hit;
  logic [2:0] sub;

  assign hit = port_is_local(port_id);
  assign sub = port_id[2:0];

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    assign addr_we[g] = wr_strobe & hit & (sub == 3'(g));
  end

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_data
    assign data_rsel[g] = hit & (sub == 3'(PORT_DATA_BASE + g));
    assign data_we[g]   = wr_strobe & data_rsel[g];
  end

  assign stat_rsel = hit & (sub == 3'(PORT_CMD));
  assign cmd_we    = wr_strobe & stat_rsel;
endmodule

// File: rtl/mio_flag_ctrl.sv
module mio_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_we,
  input  logic cmd_wr,
  input  logic cmd_rd,
  input  logic addr_touch,
  input  logic op_begun,
  input  logic rd_valid,
  output logic wrx,
  output logic rdx,
  output logic rdd,
  output logic mem_req,
  output logic mem_we,
  output logic rd_ret
);
  logic wrx_q, rdx_q, rdd_q, launched_q;
  logic wr_cmd, rd_cmd, begun_wr, begun_rd;

  // named internal events
  assign wr_cmd   = cmd_we & cmd_wr & ~wrx_q;
  assign rd_cmd   = cmd_we & cmd_rd & ~rdx_q;
  assign begun_wr = op_begun & wrx_q;
  assign begun_rd = op_begun & ~wrx_q & rdx_q & ~launched_q;
  assign rd_ret   = rd_valid & launched_q;

  assign mem_req = wrx_q | (rdx_q & ~launched_q);
  assign mem_we  = wrx_q;
  assign wrx = wrx_q;
  assign rdx = rdx_q;
  assign rdd = rdd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrx_q      <= 1'b0;
      rdx_q      <= 1'b0;
      rdd_q      <= 1'b0;
      launched_q <= 1'b0;
    end else begin
      if (wr_cmd)        wrx_q <= 1'b1;
      else if (begun_wr) wrx_q <= 1'b0;

      if (rd_cmd)      rdx_q <= 1'b1;
      else if (rd_ret) rdx_q <= 1'b0;

      if (begun_rd)    launched_q <= 1'b1;
      else if (rd_ret) launched_q <= 1'b0;

      if (rd_ret)          rdd_q <= 1'b1;
      else if (addr_touch) rdd_q <= 1'b0;
    end
  end

  // R5
  wrx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrx_q) |-> $past(cmd_we && cmd_wr));
  // R9
  wrx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrx_q && !op_begun) |=> wrx_q);
  // R6
  launch_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(launched_q) |-> !rdx_q);
  // R7
  rd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ret |=> (rdd_q && !rdx_q));
  // R8
  rdd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_touch && !rd_ret) |=> !rdd_q);
  // R10
  wr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrx_q && rdx_q && !launched_q && op_begun) |=> (!wrx_q && rdx_q && mem_req));
endmodule

// File: rtl/mio_regbank.sv
module mio_regbank
  import mio_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int DATA_BYTES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [7:0]                port_id,
  input  logic [7:0]                out_port,
  input  logic                      wr_strobe,
  output logic [7:0]                in_port,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [ADDR_BYTES*8-1:0]   mem_addr,
  output logic [DATA_BYTES*8-1:0]   mem_wdata,
  input  logic                      mem_op_begun,
  input  logic                      mem_rd_valid,
  input  logic [DATA_BYTES*8-1:0]   mem_rdata
);
  localparam int ADDR_W = ADDR_BYTES * 8;
  localparam int DATA_W = DATA_BYTES * 8;

  logic [ADDR_BYTES-1:0]      addr_we;
  logic [DATA_BYTES-1:0]      data_we, data_rsel;
  logic                       cmd_we, stat_rsel, addr_touch;
  logic                       wrx, rdx, rdd, rd_ret;
  logic [ADDR_BYTES-1:0][7:0] addr_q;
  logic [DATA_BYTES-1:0][7:0] data_q;

  mio_port_decode #(.ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES)) u_dec (
    .port_id   (port_id),
    .wr_strobe (wr_strobe),
    .addr_we   (addr_we),
    .data_we   (data_we),
    .data_rsel (data_rsel),
    .cmd_we    (cmd_we),
    .stat_rsel (stat_rsel)
  );

  assign addr_touch = |addr_we;

  mio_flag_ctrl u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .cmd_wr     (out_port[CMD_WR_BIT]),
    .cmd_rd     (out_port[CMD_RD_BIT]),
    .addr_touch (addr_touch),
    .op_begun   (mem_op_begun),
    .rd_valid   (mem_rd_valid),
    .wrx        (wrx),
    .rdx        (rdx),
    .rdd        (rdd),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .rd_ret     (rd_ret)
  );

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_areg
    always_ff @(posedge clk) begin
      if (!rst_n)          addr_q[g] <= '0;
      else if (addr_we[g]) addr_q[g] <= out_port;
    end
  end

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_dreg
    always_ff @(posedge clk) begin
      if (!rst_n)          data_q[g] <= '0;
      else if (rd_ret)     data_q[g] <= mem_rdata[g*8 +: 8];
      else if (data_we[g]) data_q[g] <= out_port;
    end
  end

  assign mem_addr  = ADDR_W'(addr_q);
  assign mem_wdata = DATA_W'(data_q);

  always_comb begin
    in_port = '0;
    for (int i = 0; i < DATA_BYTES; i++)
      if (data_rsel[i]) in_port = data_q[i];
    if (stat_rsel) in_port = status_pack(wrx, rdx, rdd);
  end

  // R7
  rd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ret |=> (mem_wdata == $past(mem_rdata)));
  // R2
  addr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we[0] |=> (mem_addr[7:0] == $past(out_port)));
endmodule

// File: tb/sim_mio_regbank.sv
module sim_mio_regbank;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  port_id = '0, out_port = '0, in_port;
  logic        wr_strobe = 1'b0;
  logic        mem_req, mem_we, mem_op_begun = 1'b0, mem_rd_valid = 1'b0;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = '0;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  mio_regbank u0 (
    .clk(clk), .rst_n(rst_n), .port_id(port_id), .out_port(out_port),
    .wr_strobe(wr_strobe), .in_port(in_port), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_op_begun(mem_op_begun), .mem_rd_valid(mem_rd_valid),
    .mem_rdata(mem_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every task starts and ends just after a falling edge
  task automatic io_wr(input logic [7:0] id, input logic [7:0] v);
    port_id = id; out_port = v; wr_strobe = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0;
  endtask

  task automatic io_rd(input logic [7:0] id, output logic [7:0] v);
    port_id = id;
    #1;
    v = in_port;
  endtask

  task automatic pulse_begun();
    mem_op_begun = 1'b1;
    @(negedge clk);
    mem_op_begun = 1'b0;
  endtask

  task automatic pulse_ret(input logic [15:0] d);
    mem_rdata = d; mem_rd_valid = 1'b1;
    @(negedge clk);
    mem_rd_valid = 1'b0;
  endtask

  task automatic chk_status(input string req, input logic [7:0] exp);
    logic [7:0] r;
    io_rd(8'h07, r);
    check(req, {24'h0, r}, {24'h0, exp});
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  logic [23:0] exp_addr;
  logic [15:0] exp_data;
  logic [7:0]  pid, v, r, e;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 addr", {8'h0, mem_addr}, 32'h0);
    check("R1 data", {16'h0, mem_wdata}, 32'h0);
    check("R1 req", {31'h0, mem_req}, 32'h0);
    chk_status("R1 status", 8'h00);

    // R2 R3 R4: write sweep over all 256 port numbers
    exp_addr = '0; exp_data = '0;
    for (int id = 0; id < 256; id++) begin
      pid = 8'(id);
      v = 8'(id * 37 + 11);
      if (pid[2:0] == 3'd7) v = v & 8'hFC;  // no command bits
      io_wr(pid, v);
      if (!pid[3]) begin
        case (pid[2:0])
          3'd0: exp_addr[7:0]   = v;
          3'd1: exp_addr[15:8]  = v;
          3'd2: exp_addr[23:16] = v;
          3'd4: exp_data[7:0]   = v;
          3'd5: exp_data[15:8]  = v;
          default: ;
        endcase
      end
      check("R2 addr sweep", {8'h0, mem_addr}, {8'h0, exp_addr});
      check("R3 data sweep", {16'h0, mem_wdata}, {16'h0, exp_data});
    end
    chk_status("R9 status after sweep", 8'h00);

    // R3 R4: read sweep
    for (int id = 0; id < 256; id++) begin
      pid = 8'(id);
      io_rd(pid, r);
      e = 8'h00;
      if (!pid[3] && pid[2:0] == 3'd4) e = exp_data[7:0];
      if (!pid[3] && pid[2:0] == 3'd5) e = exp_data[15:8];
      check("R4 read sweep", {24'h0, r}, {24'h0, e});
    end
    @(negedge clk);

    io_wr(8'h00, 8'h34); io_wr(8'h01, 8'h12); io_wr(8'h02, 8'hAB);
    io_wr(8'h04, 8'hCD); io_wr(8'h05, 8'hEF);
    check("R2 addr", {8'h0, mem_addr}, 32'h00AB1234);
    check("R3 data", {16'h0, mem_wdata}, 32'h0000EFCD);

    // R5 store
    io_wr(8'h07, 8'h02);
    chk_status("R5 wrx set", 8'h04);
    check("R5 req", {30'h0, mem_req, mem_we}, 32'h3);
    io_wr(8'h07, 8'h02);  // R9 repeat while pending
    pulse_begun();
    chk_status("R9 repeat store ignored", 8'h00);
    check("R5 req drop", {31'h0, mem_req}, 32'h0);
    pulse_begun();        // no request: no effect
    chk_status("R5 idle begun", 8'h00);

    // R6 load
    io_wr(8'h07, 8'h01);
    chk_status("R6 rdx set", 8'h02);
    check("R6 req", {30'h0, mem_req, mem_we}, 32'h2);
    pulse_begun();
    check("R6 req drop", {31'h0, mem_req}, 32'h0);
    chk_status("R6 rdx held", 8'h02);
    io_wr(8'h07, 8'h01);  // R9 ignored
    check("R9 repeat load ignored", {31'h0, mem_req}, 32'h0);
    pulse_ret(16'hBEEF);
    chk_status("R7 done", 8'h01);
    io_rd(8'h04, r); check("R7 lo", {24'h0, r}, 32'hEF);
    io_rd(8'h05, r); check("R7 hi", {24'h0, r}, 32'hBE);
    @(negedge clk);

    // R8 address write clears read-done
    io_wr(8'h01, 8'h55);
    chk_status("R8 rdd clear", 8'h00);
    check("R8 addr", {8'h0, mem_addr}, 32'h00AB5534);

    // R7 stray return ignored
    pulse_ret(16'h1234);
    check("R7 stray data", {16'h0, mem_wdata}, 32'h0000BEEF);
    chk_status("R7 stray status", 8'h00);

    // R10 both pending
    io_wr(8'h07, 8'h03);
    chk_status("R10 both", 8'h06);
    check("R10 store first", {30'h0, mem_req, mem_we}, 32'h3);
    pulse_begun();
    chk_status("R10 store retired", 8'h02);
    check("R10 load next", {30'h0, mem_req, mem_we}, 32'h2);
    pulse_begun();
    check("R10 load launched", {31'h0, mem_req}, 32'h0);

    // R7 collision: data port write and return together
    port_id = 8'h04; out_port = 8'h11; wr_strobe = 1'b1;
    mem_rdata = 16'hC0DE; mem_rd_valid = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0; mem_rd_valid = 1'b0;
    check("R7 return wins", {16'h0, mem_wdata}, 32'h0000C0DE);
    chk_status("R7 collide status", 8'h01);

    // R8 collision: address write and return together
    io_wr(8'h07, 8'h01);
    pulse_begun();
    port_id = 8'h02; out_port = 8'h77; wr_strobe = 1'b1;
    mem_rdata = 16'h4242; mem_rd_valid = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0; mem_rd_valid = 1'b0;
    chk_status("R8 return keeps rdd", 8'h01);
    check("R8 addr taken", {8'h0, mem_addr}, 32'h00775534);
    check("R8 data", {16'h0, mem_wdata}, 32'h00004242);

    summary();
    $finish;
  end
endmodule